// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block lets a clocked system reach an external asynchronous static RAM, by default 64K locations of 8 bits. On the system side a single request port carries a read/write select, an address and write data, and it is accepted with a valid/ready handshake. A read returns its byte on a separate output, flagged by a one-clock valid strobe. On the memory side the block drives the address, two chip selects of opposite polarity, an active-low output enable and an active-low write enable. The bidirectional data bus is split into an output value, an output-enable and an input value, so that the pad or tristate can be placed outside the block.

The memory has no clock, so every phase of a memory cycle is timed by counting system clocks. Each phase length is derived at elaboration from a nanosecond limit and the clock period by ceiling division, with a minimum of one clock. A write asserts write enable first with the data drivers off, to give the memory time to release the bus. It then drives the data for the setup window and ends the write by raising write enable while the chip stays selected, so that the data and address are still held. A bus-idle gap follows before the next request is taken. All memory-side strobes come straight from registers, so they carry no glitches.

Top module: `sram_ctrl`

## Requirements
- R1: While `req_ready` is 1 the memory is in standby: `sram_ce1_n`=1, `sram_ce2`=0, `sram_oe_n`=1, `sram_we_n`=1, `sram_dq_oe`=0. The same holds out of reset, together with `rd_valid`=0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 for the whole cycle: TRC clocks for a read (`req_write`=0), or TURN+DATA+HOLD+TURN clocks for a write (`req_write`=1).
- R3: A read holds the address with `sram_ce1_n`=0, `sram_ce2`=1, `sram_we_n`=1 and `sram_oe_n`=0 for exactly TRC consecutive clocks.
- R4: The data input is sampled on the last clock of a read. `rd_valid` is 1 for exactly one clock, the first clock in which `req_ready` is 1 again, and `rd_data` then holds the sampled byte.
- R5: During a write `sram_oe_n` stays 1, and `sram_we_n` is 0 for exactly TURN+DATA clocks with both chip selects active. TURN+DATA is at least the write-pulse count.
- R6: During the first TURN clocks of write enable low, `sram_dq_oe` is 0. The write data is then driven unchanged for DATA clocks before `sram_we_n` rises, with DATA no less than the data-setup count, and it is still driven in the clock where `sram_we_n` rises.
- R7: A write is ended by `sram_we_n` rising while both chip selects remain active, and the address does not change while the chip is selected.
- R8: After a write come TURN clocks in which the memory is deselected, `sram_dq_oe`=0 and `req_ready`=0. A read that follows a write therefore never meets a driven bus.
- R9: With clock period P, the counts are TRC=ceil(cycle/P), TWP=ceil(pulse/P), TSU=ceil(setup/P) and TURN=ceil(release/P), each at least 1. DATA=max(TSU, TWP-TURN, 1), and HOLD=max(1, TRC-TURN-DATA).
- R10: A request presented while `req_ready` is 0 is ignored. It causes no memory access, and the stored data is unchanged.
- R11: `sram_dq_oe` is never 1 while the memory is enabled to drive the bus, that is while `sram_oe_n`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Byte returned by the last read |
| rd_valid | output | 1 | One-clock strobe for rd_data |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_ce1_n | output | 1 | Active-low chip select |
| sram_ce2 | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_dq_out | output | DATA_W | Data driven toward the memory |
| sram_dq_oe | output | 1 | Enable of the controller's data drivers |
| sram_dq_in | input | DATA_W | Data read from the memory bus |

## Verification
The bench uses a 16-location configuration with a 35 ns grade on a 10 ns clock. It fills every location with an arithmetic pattern and reads it back in ascending order, which separates address mapping faults from data faults. It then writes each location and reads it back at once with a complemented walking-bit pattern, so every read follows a write and depends on the bus gap. A descending re-read then exposes stale captures. The memory model returns unknown data until the address has been held for the full read count, flags bus contention, and counts the write pulse, the driver-off window, the data window and the hold in clocks. A noise write sent during a busy read, and all-zero and all-one bytes at the end addresses, cover the ignored-request and data-extreme cases.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSETUP,
        ST_WDATA,
        ST_WHOLD,
        ST_GAP
    } sram_state_e;

    // Clock count covering t_ns at a clk_ns period, never below one.
    function automatic int unsigned cyc_from_ns(input int unsigned t_ns,
                                                input int unsigned clk_ns);
        int unsigned q;
        q = (t_ns + clk_ns - 1) / clk_ns;
        return (q == 0) ? 1 : q;
    endfunction

    function automatic int unsigned max_u(input int unsigned a,
                                          input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } cap_t;

    cap_t cap_d;
    cap_t cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = sample_i;
        if (sample_i) begin
            cap_d.data = dq_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rd_data_o  = cap_q.data;
    assign rd_valid_o = cap_q.valid;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_CYCLE_NS    = 15,
    parameter int T_WEPULSE_NS  = 10,
    parameter int T_DSETUP_NS   = 8,
    parameter int T_RELEASE_NS  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    import sram_ctrl_pkg::*;

    // Phase lengths in clocks
    localparam int unsigned TRC_CYC    = cyc_from_ns(T_CYCLE_NS, CLK_PERIOD_NS);
    localparam int unsigned TWP_CYC    = cyc_from_ns(T_WEPULSE_NS, CLK_PERIOD_NS);
    localparam int unsigned TSETUP_CYC = cyc_from_ns(T_DSETUP_NS, CLK_PERIOD_NS);
    localparam int unsigned TTURN_CYC  = cyc_from_ns(T_RELEASE_NS, CLK_PERIOD_NS);
    localparam int unsigned DATA_CYC   = max_u(TSETUP_CYC,
                                          (TWP_CYC > TTURN_CYC) ? TWP_CYC - TTURN_CYC : 1);
    localparam int unsigned HOLD_CYC   = (TRC_CYC > TTURN_CYC + DATA_CYC)
                                          ? TRC_CYC - TTURN_CYC - DATA_CYC : 1;
    localparam int unsigned MAX_CYC    = max_u(max_u(TRC_CYC, TTURN_CYC),
                                               max_u(DATA_CYC, HOLD_CYC));
    localparam int          CNT_W      = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] LD_READ = CNT_W'(TRC_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TTURN_CYC - 1);
    localparam logic [CNT_W-1:0] LD_DATA = CNT_W'(DATA_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        sram_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce1_n;
        logic              ce2;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        state: ST_IDLE,
        addr:  '0,
        wdata: '0,
        ce1_n: 1'b1,
        ce2:   1'b0,
        oe_n:  1'b1,
        we_n:  1'b1,
        dq_oe: 1'b0
    };

    ctrl_t            ctrl_d;
    ctrl_t            ctrl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             rd_sample;
    logic             chip_on;

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    always_comb begin
        ctrl_d   = ctrl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;

        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctrl_d.addr  = req_addr;
                    ctrl_d.wdata = req_wdata;
                    tmr_load     = 1'b1;
                    if (req_write) begin
                        ctrl_d.state = ST_WSETUP;
                        tmr_val      = LD_TURN;
                    end else begin
                        ctrl_d.state = ST_READ;
                        tmr_val      = LD_READ;
                    end
                end
            end
            ST_READ: begin
                if (tmr_expired) begin
                    ctrl_d.state = ST_IDLE;
                end
            end
            ST_WSETUP: begin
                if (tmr_expired) begin
                    ctrl_d.state = ST_WDATA;
                    tmr_load     = 1'b1;
                    tmr_val      = LD_DATA;
                end
            end
            ST_WDATA: begin
                if (tmr_expired) begin
                    ctrl_d.state = ST_WHOLD;
                    tmr_load     = 1'b1;
                    tmr_val      = LD_HOLD;
                end
            end
            ST_WHOLD: begin
                if (tmr_expired) begin
                    ctrl_d.state = ST_GAP;
                    tmr_load     = 1'b1;
                    tmr_val      = LD_TURN;
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    ctrl_d.state = ST_IDLE;
                end
            end
            default: begin
                ctrl_d.state = ST_IDLE;
            end
        endcase

        // Registered strobes follow the next state
        chip_on      = ctrl_d.state inside {ST_READ, ST_WSETUP, ST_WDATA, ST_WHOLD};
        ctrl_d.ce1_n = !chip_on;
        ctrl_d.ce2   = chip_on;
        ctrl_d.oe_n  = (ctrl_d.state != ST_READ);
        ctrl_d.we_n  = !(ctrl_d.state inside {ST_WSETUP, ST_WDATA});
        ctrl_d.dq_oe = ctrl_d.state inside {ST_WDATA, ST_WHOLD};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign rd_sample = (ctrl_q.state == ST_READ) && tmr_expired;

    sram_read_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_i   (rd_sample),
        .dq_i       (sram_dq_in),
        .rd_data_o  (rd_data),
        .rd_valid_o (rd_valid)
    );

    assign req_ready   = (ctrl_q.state == ST_IDLE);
    assign sram_addr   = ctrl_q.addr;
    assign sram_ce1_n  = ctrl_q.ce1_n;
    assign sram_ce2    = ctrl_q.ce2;
    assign sram_oe_n   = ctrl_q.oe_n;
    assign sram_we_n   = ctrl_q.we_n;
    assign sram_dq_out = ctrl_q.wdata;
    assign sram_dq_oe  = ctrl_q.dq_oe;

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce1_n,
    input logic              sram_ce2,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic              sram_dq_oe
);

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce1_n && !sram_ce2 && sram_oe_n && sram_we_n && !sram_dq_oe)); // R1

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2

    AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_ce1_n && sram_ce2 && sram_we_n)); // R3

    AST_RVALID_AT_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (req_ready && $past(!sram_oe_n))); // R4

    AST_WRITE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce1_n && sram_ce2 && sram_oe_n)); // R5

    AST_DRIVE_INSIDE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> !sram_we_n); // R6

    AST_DATA_HELD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (sram_dq_oe && $stable(sram_dq_out))); // R6

    AST_WE_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_ce1_n && sram_ce2)); // R7

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce1_n && $past(!sram_ce1_n)) |-> $stable(sram_addr)); // R7

    AST_GAP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_dq_oe) |-> (!req_ready && sram_ce1_n && !sram_ce2)); // R8

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_dq_oe && !sram_oe_n)); // R11

endmodule

bind sram_ctrl sram_ctrl_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rd_valid    (rd_valid),
    .sram_addr   (sram_addr),
    .sram_ce1_n  (sram_ce1_n),
    .sram_ce2    (sram_ce2),
    .sram_oe_n   (sram_oe_n),
    .sram_we_n   (sram_we_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

    localparam int AW   = 4;
    localparam int DW   = 8;
    localparam int CLKN = 10;
    localparam int TCYN = 35;
    localparam int TWPN = 20;
    localparam int TSUN = 15;
    localparam int TRLN = 12;
    localparam int NLOC = 1 << AW;

    function automatic int cdiv(input int a, input int b);
        int q;
        q = (a + b - 1) / b;
        return (q < 1) ? 1 : q;
    endfunction

    localparam int E_TRC  = cdiv(TCYN, CLKN);
    localparam int E_TWP  = cdiv(TWPN, CLKN);
    localparam int E_TSU  = cdiv(TSUN, CLKN);
    localparam int E_TURN = cdiv(TRLN, CLKN);
    localparam int E_DATA = (E_TSU > E_TWP - E_TURN) ? ((E_TSU < 1) ? 1 : E_TSU) : E_TWP - E_TURN;
    localparam int E_HOLD = (E_TRC - E_TURN - E_DATA > 1) ? E_TRC - E_TURN - E_DATA : 1;
    localparam int E_WBUSY = E_TURN + E_DATA + E_HOLD + E_TURN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic [AW-1:0] sram_addr;
    logic          sram_ce1_n;
    logic          sram_ce2;
    logic          sram_oe_n;
    logic          sram_we_n;
    logic [DW-1:0] sram_dq_out;
    logic          sram_dq_oe;
    logic [DW-1:0] sram_dq_in;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] mem_m   [NLOC];
    logic [DW-1:0] exp_mem [NLOC];

    always #5 clk = ~clk;

    sram_ctrl #(
        .ADDR_W        (AW),
        .DATA_W        (DW),
        .CLK_PERIOD_NS (CLKN),
        .T_CYCLE_NS    (TCYN),
        .T_WEPULSE_NS  (TWPN),
        .T_DSETUP_NS   (TSUN),
        .T_RELEASE_NS  (TRLN)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .sram_addr   (sram_addr),
        .sram_ce1_n  (sram_ce1_n),
        .sram_ce2    (sram_ce2),
        .sram_oe_n   (sram_oe_n),
        .sram_we_n   (sram_we_n),
        .sram_dq_out (sram_dq_out),
        .sram_dq_oe  (sram_dq_oe),
        .sram_dq_in  (sram_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Memory model: data valid only after the address was held for E_TRC clocks
    logic rd_cond;
    int   rd_age = 0;
    assign rd_cond = !sram_ce1_n && sram_ce2 && !sram_oe_n && sram_we_n;
    assign sram_dq_in = (rd_cond && rd_age >= E_TRC) ? mem_m[sram_addr] : 'x;

    bit            rd_prev = 1'b0;
    logic [AW-1:0] rd_addr_p = '0;
    bit            wr_prev = 1'b0;
    logic [AW-1:0] wr_addr_p = '0;
    logic [DW-1:0] wr_last = '0;
    int            wr_len = 0;
    int            off_len = 0;
    int            data_len = 0;

    always @(negedge clk) begin
        bit wr_cond;
        if (rst_n) begin
            wr_cond = !sram_ce1_n && sram_ce2 && !sram_we_n;
            chk(!(sram_dq_oe && !sram_oe_n), "R11 contention", int'(sram_dq_oe), 0);
            if (rd_cond) begin
                rd_age = (rd_prev && sram_addr == rd_addr_p) ? rd_age + 1 : 1;
            end else begin
                rd_age = 0;
            end
            rd_prev   = rd_cond;
            rd_addr_p = sram_addr;

            if (wr_cond) begin
                if (!sram_oe_n) chk(1'b0, "R5 oe during write", 0, 1);
                if (wr_len > 0 && sram_addr != wr_addr_p)
                    chk(1'b0, "R7 addr moved", int'(sram_addr), int'(wr_addr_p));
                wr_len++;
                if (!sram_dq_oe) begin
                    if (data_len != 0) chk(1'b0, "R6 driver dropped", data_len, 0);
                    off_len++;
                end else begin
                    data_len = (data_len > 0 && sram_dq_out != wr_last) ? 1 : data_len + 1;
                    wr_last  = sram_dq_out;
                end
                wr_addr_p = sram_addr;
            end else if (wr_prev) begin
                chk(wr_len == E_TURN + E_DATA && wr_len >= E_TWP, "R5 we pulse", wr_len, E_TURN + E_DATA);
                chk(off_len == E_TURN, "R6 driver-off window", off_len, E_TURN);
                chk(data_len == E_DATA && data_len >= E_TSU, "R6 data window", data_len, E_DATA);
                chk(sram_dq_oe && sram_dq_out == wr_last, "R6 hold", int'(sram_dq_out), int'(wr_last));
                chk(!sram_ce1_n && sram_ce2 && sram_addr == wr_addr_p, "R7 we ends write",
                    int'(sram_ce2), 1);
                mem_m[wr_addr_p] = wr_last;
                wr_len   = 0;
                off_len  = 0;
                data_len = 0;
            end
            wr_prev = wr_cond;
        end
    end

    task automatic check_idle(input string tag);
        chk(req_ready && sram_ce1_n && !sram_ce2 && sram_oe_n && sram_we_n && !sram_dq_oe,
            tag, int'({req_ready, sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe}), 6'b110110);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        check_idle("R1 idle before write");
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!req_ready) begin
            n++;
            if (n > 50) break;
            @(negedge clk);
        end
        chk(n == E_WBUSY, "R2 R8 R9 write busy clocks", n, E_WBUSY);
        exp_mem[a] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input bit noise, input logic [AW-1:0] na);
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!req_ready) begin
            n++;
            if (n > 50) break;
            if (rd_valid) chk(1'b0, "R4 early valid", 1, 0);
            if (noise && n == 1) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = na; req_wdata = ~exp_mem[na];
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(n == E_TRC, "R2 R3 R9 read busy clocks", n, E_TRC);
        chk(rd_valid == 1'b1, "R4 valid on return", int'(rd_valid), 1);
        chk(rd_data === exp_mem[a], "R4 read data", int'(rd_data), int'(exp_mem[a]));
        @(negedge clk);
        chk(rd_valid == 1'b0, "R4 single pulse", int'(rd_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WATCHDOG", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NLOC; i++) begin
            mem_m[i]   = 8'h00;
            exp_mem[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        chk(rd_valid == 1'b0, "R1 reset rd_valid", int'(rd_valid), 0);
        check_idle("R1 reset standby");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");

        // Ascending fill and read-back
        for (int a = 0; a < NLOC; a++) do_write(AW'(a), DW'(a * 37 + 5));
        for (int a = 0; a < NLOC; a++) do_read(AW'(a), 1'b0, '0);

        // Read immediately after each write, walking bit over complement
        for (int a = 0; a < NLOC; a++) begin
            do_write(AW'(a), ~DW'(a * 37 + 5) ^ DW'(1 << (a % DW)));
            do_read(AW'(a), 1'b0, '0);
        end
        for (int a = NLOC - 1; a >= 0; a--) do_read(AW'(a), 1'b0, '0);

        // R10: write request during a busy read must be dropped
        do_read(AW'(3), 1'b1, AW'(5));
        do_read(AW'(5), 1'b0, '0);
        chk(mem_m[5] === exp_mem[5], "R10 noise ignored", int'(mem_m[5]), int'(exp_mem[5]));

        // Data extremes at the end addresses
        do_write('0, 8'h00);
        do_write(AW'(NLOC - 1), 8'hFF);
        do_read('0, 1'b0, '0);
        do_read(AW'(NLOC - 1), 1'b0, '0);
        @(negedge clk);
        check_idle("R1 final idle");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule